// File: doc/BRIEF.md
# Buffered synchronous stream FIFO

This block is a single-clock FIFO with a valid/ready handshake on its write side and on its read side. Its storage is a memory that can only be read synchronously. Read data comes back one cycle after the address, or two cycles when an extra memory output register is switched on. A prefetch stage hides that delay. It issues memory reads ahead of demand into a small holding queue built from registers, so the read side behaves as a first-word-fall-through stream. The output never comes straight from the memory read path.

A second parameter adds a forward register slice after the holding queue, which cuts the path from the FIFO to downstream logic. The slice's data register acts as a one-entry FIFO and its valid flag as that FIFO's level. Its upstream ready is the downstream ready passed straight through. Both sides share one clock and one synchronous active-low reset.

Top module: `bsf_top`

## Requirements
- R1: While `rst_n` is low, `in_ready` is low. In the first cycle after reset is released, `out_valid` is low and `in_ready` is high.
- R2: Start from an empty FIFO with `out_ready` held low and `in_valid` held high. Exactly DEPTH words are accepted, and then `in_ready` stays low.
- R3: Every word accepted on the write side (`in_valid` and `in_ready` high at a clock edge) leaves on the read side (`out_valid` and `out_ready` high at an edge) exactly once and in acceptance order. This holds for any pattern of valid and ready, including a write and a read together on an empty FIFO.
- R4: With `out_ready` high, a word written into an empty FIFO at clock edge E0 first shows on `out_valid` right after edge E0+L. L = 1 + (1 when MEM_OUTREG is 0, 2 when it is 1) + (1 when OUT_SLICE is 1, else 0).
- R5: With `in_valid` and `out_ready` held high, after start-up the block moves one word per clock on both sides.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change in the next cycle. With OUT_SLICE set, the slice loads nothing while `out_ready` is low, so a FIFO filled with `out_ready` low shows `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Write-side word present |
| in_ready | output | 1 | FIFO can take a word |
| in_data | input | DW | Write-side word |
| out_valid | output | 1 | Read-side word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DW | Read-side word |

## Verification
The bench targets the prefetch credit limit. If it ignores the words still in flight, the holding queue overruns and words are lost or duplicated. If it is too strict, it stalls every other cycle, and the throughput window exposes this. The fill test counts accepted words against DEPTH. A capacity that ignores prefetched words would accept more than DEPTH, and one that counts them twice would accept fewer. The first-word latency is measured for each memory-latency and slice setting, so a missing or extra register stage shows as an off-by-one, while long random valid/ready runs in three densities catch reordering around empty-FIFO write/read overlap.

// File: rtl/bsf_pkg.sv
// Shared helpers for the buffered stream FIFO.
package bsf_pkg;
    // Read latency of the storage array in cycles for a given output-register choice.
    function automatic int rd_latency(input bit outreg);
        return outreg ? 2 : 1;
    endfunction
endpackage

// File: rtl/bsf_mem.sv
// Storage array with one write port and one synchronous read port.
// Assumes the controller never reads an address in the cycle it writes it.
// Read data is valid 1 cycle after re, or 2 cycles with OUTREG set.
module bsf_mem #(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter bit OUTREG = 1'b0,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] rd_q;

    // Write port.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Synchronous read port.
    always_ff @(posedge clk) begin
        if (re) rd_q <= cells[raddr];
    end

    generate
        if (OUTREG) begin : g_outreg
            logic [DW-1:0] rd_q2;
            // Optional second read register.
            always_ff @(posedge clk) rd_q2 <= rd_q;
            assign rdata = rd_q2;
        end else begin : g_noreg
            assign rdata = rd_q;
        end
    endgenerate
endmodule

// File: rtl/bsf_ctrl.sv
// Pointer and prefetch controller.
// Three pointers, one bit wider than the address: write, issue (memory read
// sent) and consume (word left the holding queue). Capacity counts every word
// not yet consumed. Reads are issued only while the holding queue has room for
// all reads in flight, counting the pop of this cycle.
module bsf_ctrl #(
    parameter int DEPTH = 16,
    parameter int LAT   = 1,
    parameter int HQ    = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int CW   = $clog2(HQ + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          pop,
    input  logic [CW-1:0] hq_cnt,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic          mem_re,
    output logic [AW-1:0] raddr,
    output logic          ret
);
    logic [PW-1:0]  wptr, rptr, cptr;
    logic [LAT-1:0] flight;
    logic           full, avail, credit;

    assign full     = (wptr - cptr) == PW'(DEPTH);
    assign in_ready = rst_n & ~full;
    assign mem_we   = in_valid & in_ready;
    assign waddr    = wptr[AW-1:0];
    assign raddr    = rptr[AW-1:0];
    assign avail    = wptr != rptr;
    assign credit   = (int'(hq_cnt) + $countones(flight) - int'(pop)) < HQ;
    assign mem_re   = rst_n & avail & credit;
    assign ret      = flight[LAT-1];

    // Pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cptr <= '0;
        end else begin
            if (mem_we) wptr <= wptr + 1'b1;
            if (mem_re) rptr <= rptr + 1'b1;
            if (pop)    cptr <= cptr + 1'b1;
        end
    end

    // One flag per memory latency stage marks reads in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flight <= '0;
        end else begin
            flight[0] <= mem_re;
            for (int i = 1; i < LAT; i++) flight[i] <= flight[i-1];
        end
    end

    // R2: stored words never exceed DEPTH.
    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - cptr) <= PW'(DEPTH));

    // R3: the issue pointer stays between consume and write pointers.
    assert_issue_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rptr) <= (wptr - cptr));
endmodule

// File: rtl/bsf_holdq.sv
// Small register queue that catches prefetched memory words and presents the
// head as a first-word-fall-through output. Assumes the controller never
// pushes into a full queue that is not popping in the same cycle.
module bsf_holdq #(
    parameter int DW  = 8,
    parameter int HQ  = 2,
    localparam int IW = (HQ > 1) ? $clog2(HQ) : 1,
    localparam int CW = $clog2(HQ + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic [CW-1:0] cnt
);
    logic [DW-1:0] slot [HQ];
    logic [IW-1:0] head, tail;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] i);
        return (i == IW'(HQ - 1)) ? '0 : i + 1'b1;
    endfunction

    assign valid = cnt != '0;
    assign data  = slot[head];

    // Index and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // Slot storage.
    always_ff @(posedge clk) begin
        if (push) slot[tail] <= push_data;
    end

    // R3: a push never lands in a full queue.
    assert_holdq_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt < CW'(HQ)));

    // R6: a stalled head word stays put.
    assert_head_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> (valid && $stable(data)));

    // R1: empty right after reset.
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !valid);
endmodule

// File: rtl/bsf_slice.sv
// Forward register slice. Upstream ready is downstream ready passed through.
// Data and valid load together whenever downstream is ready, so the data
// register is a one-entry FIFO whose level is the valid flag.
module bsf_slice #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [DW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [DW-1:0] dn_data
);
    assign up_ready = dn_ready;

    // Valid flag: occupancy of the one-entry stage.
    always_ff @(posedge clk) begin
        if (!rst_n)        dn_valid <= 1'b0;
        else if (dn_ready) dn_valid <= up_valid;
    end

    // Data register.
    always_ff @(posedge clk) begin
        if (dn_ready) dn_data <= up_data;
    end

    // R6: a stalled slice word stays put.
    assert_slice_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
endmodule

// File: rtl/bsf_top.sv
// Buffered synchronous stream FIFO: synchronous-read storage, prefetch into a
// register holding queue, optional forward slice. Single clock, synchronous
// active-low reset. DEPTH must be a power of two, at least 2.
module bsf_top #(
    parameter int DW         = 8,
    parameter int DEPTH      = 16,
    parameter bit MEM_OUTREG = 1'b0,
    parameter bit OUT_SLICE  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int LAT = bsf_pkg::rd_latency(MEM_OUTREG);
    localparam int HQ  = LAT + 1;
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = $clog2(HQ + 1);

    logic          mem_we, mem_re, ret, pop, hq_valid, hq_ready;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] rdata, hq_data;
    logic [CW-1:0] hq_cnt;

    assign pop = hq_valid & hq_ready;

    bsf_ctrl #(.DEPTH(DEPTH), .LAT(LAT), .HQ(HQ)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .pop(pop), .hq_cnt(hq_cnt), .mem_we(mem_we), .waddr(waddr),
        .mem_re(mem_re), .raddr(raddr), .ret(ret)
    );

    bsf_mem #(.DW(DW), .DEPTH(DEPTH), .OUTREG(MEM_OUTREG)) mem_i (
        .clk(clk), .we(mem_we), .waddr(waddr), .wdata(in_data),
        .re(mem_re), .raddr(raddr), .rdata(rdata)
    );

    bsf_holdq #(.DW(DW), .HQ(HQ)) holdq_i (
        .clk(clk), .rst_n(rst_n), .push(ret), .push_data(rdata), .pop(pop),
        .valid(hq_valid), .data(hq_data), .cnt(hq_cnt)
    );

    generate
        if (OUT_SLICE) begin : g_slice
            bsf_slice #(.DW(DW)) slice_i (
                .clk(clk), .rst_n(rst_n), .up_valid(hq_valid), .up_ready(hq_ready),
                .up_data(hq_data), .dn_valid(out_valid), .dn_ready(out_ready),
                .dn_data(out_data)
            );
        end else begin : g_direct
            assign out_valid = hq_valid;
            assign out_data  = hq_data;
            assign hq_ready  = out_ready;
        end
    endgenerate
endmodule

// File: tb/bsf_top_tb_top.sv
// Per-configuration bench: drives one DUT and scores it against the requirements.
module bsf_bench #(
    parameter bit MEMREG = 1'b0,
    parameter bit SLICE  = 1'b0,
    parameter int DEPTH  = 8
) (
    input  logic clk,
    output logic done,
    output int   nchk,
    output int   nbad
);
    localparam int LAT   = MEMREG ? 2 : 1;
    localparam int EXP_L = 1 + LAT + (SLICE ? 1 : 0);

    logic       rst_n, in_valid, in_ready, out_valid, out_ready;
    logic [7:0] in_data, out_data;
    int         expq [$];
    int         in_cnt, out_cnt;
    bit         mon_en, acc;

    bsf_top #(.DW(8), .DEPTH(DEPTH), .MEM_OUTREG(MEMREG), .OUT_SLICE(SLICE)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s memreg=%0d slice=%0d actual=%0d expected=%0d",
                     req, MEMREG, SLICE, act, exp);
        end
    endtask

    // Monitor between edges: records handshakes that occur at the next edge.
    always @(negedge clk) begin
        acc = in_valid && in_ready;
        if (mon_en) begin
            if (in_valid && in_ready) begin
                expq.push_back(int'(in_data));
                in_cnt++;
            end
            if (out_valid && out_ready) begin
                out_cnt++;
                if (expq.size() == 0) chk(1'b0, "R3 extra word", int'(out_data), -1);
                else begin
                    int e;
                    e = expq.pop_front();
                    chk(int'(out_data) == e, "R3 order", int'(out_data), e);
                end
            end
        end
    end

    // Advance one clock; the next word is offered once the last one was taken.
    task automatic step();
        @(posedge clk);
        #1;
        if (acc) in_data = in_data + 8'd1;
    endtask

    initial begin
        done = 0; nchk = 0; nbad = 0; in_cnt = 0; out_cnt = 0; mon_en = 0; acc = 0;
        rst_n = 0; in_valid = 0; out_ready = 0; in_data = 8'd0;
        repeat (3) step();
        chk(in_ready == 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
        rst_n = 1;
        step();
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        mon_en = 1;

        // R2: fill with no reads.
        begin
            int c0;
            c0 = in_cnt;
            in_valid = 1;
            repeat (DEPTH + 12) step();
            in_valid = 0;
            chk(in_cnt - c0 == DEPTH, "R2 accepted words", in_cnt - c0, DEPTH);
            chk(in_ready == 1'b0, "R2 in_ready when full", int'(in_ready), 0);
        end

        // R6: stall holds the output.
        begin
            logic       v0;
            logic [7:0] d0;
            v0 = out_valid; d0 = out_data;
            chk(out_valid == !SLICE, "R6 valid while stalled", int'(out_valid), int'(!SLICE));
            repeat (4) step();
            chk(out_valid == v0, "R6 valid stable", int'(out_valid), int'(v0));
            if (v0) chk(out_data == d0, "R6 data stable", int'(out_data), int'(d0));
        end

        // Drain the full FIFO.
        out_ready = 1;
        repeat (DEPTH + 10) step();
        chk(expq.size() == 0, "R3 drained after fill", expq.size(), 0);

        // R4: first-word latency.
        begin
            int k;
            in_valid = 1;
            step();
            in_valid = 0;
            k = 0;
            while (!out_valid && k < 20) begin
                step();
                k++;
            end
            chk(k == EXP_L, "R4 first-word latency", k, EXP_L);
        end
        repeat (8) step();

        // R5: full throughput.
        begin
            int o0, i0;
            in_valid = 1;
            repeat (12) step();
            o0 = out_cnt; i0 = in_cnt;
            repeat (20) step();
            chk(out_cnt - o0 == 20, "R5 output rate", out_cnt - o0, 20);
            chk(in_cnt - i0 == 20, "R5 input rate", in_cnt - i0, 20);
            in_valid = 0;
        end
        repeat (10) step();

        // R3: random valid and ready in three densities.
        for (int ph = 0; ph < 3; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                int rv, rr;
                rv = int'($urandom % 4);
                rr = int'($urandom % 4);
                case (ph)
                    0: begin in_valid = rv != 0; out_ready = rr == 0; end
                    1: begin in_valid = rv == 0; out_ready = rr != 0; end
                    default: begin in_valid = rv[0]; out_ready = rr[0]; end
                endcase
                step();
            end
        end
        in_valid = 0; out_ready = 1;
        repeat (DEPTH + 10) step();
        chk(expq.size() == 0, "R3 drained after random", expq.size(), 0);
        chk(in_cnt == out_cnt, "R3 word count", out_cnt, in_cnt);
        done = 1;
    end
endmodule

// Top bench: one scorer per memory-latency and slice setting.
module bsf_top_tb_top;
    logic       clk = 1'b0;
    logic [3:0] done;
    int         nchk [4];
    int         nbad [4];

    always #5 clk = ~clk;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_cfg
            bsf_bench #(.MEMREG((g % 2) == 1), .SLICE(g >= 2), .DEPTH(8)) cfg_i (
                .clk(clk), .done(done[g]), .nchk(nchk[g]), .nbad(nbad[g])
            );
        end
    endgenerate

    initial begin
        int cyc, total, bad;
        cyc = 0;
        #1;
        while (done !== 4'hF && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        #2;
        total = 0; bad = 0;
        for (int i = 0; i < 4; i++) begin
            total += nchk[i];
            bad   += nbad[i];
        end
        if (done !== 4'hF) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule